// File: doc/BRIEF.md
# Sub-Word Operand Extract and Modifier Unit

This combinational unit prepares one 32-bit lane value to be an operand of a later compare or arithmetic step. A 3-bit select code picks one of the four bytes, one of the two 16-bit halves, or the whole word. The chosen field is zero-extended to 32 bits. Up to three modifiers are then applied to it: absolute value, negate and sign-extend.

What each modifier does depends on a 2-bit operand kind input. The kinds are unsigned integer (0), signed integer (1) and floating point (2); code 3 is reserved. The modifiers always run in the order magnitude, then negation, then extension. Each step tests the top bit of the field width on the value that the previous step produced. Combinations that make no sense raise a flag. In that case the value passes through without any modifier, so a consumer can trap the operand and still see a predictable value.

Top module: `opsel_modify_unit`

## Requirements
- R1: Select codes 0 to 3 output byte k (bits 8k+7 down to 8k) of the lane, zero-extended to 32 bits, when no modifier is requested.
- R2: Select code 4 outputs bits 15:0 and code 5 outputs bits 31:16, both zero-extended. Code 6 outputs the whole word.
- R3: Select codes 7 and above raise the illegal flag and output the lane value unchanged, whatever the kind and modifiers.
- R4: With abs on the signed kind, a field whose top bit is set is sign-extended and replaced by its 32-bit two's-complement magnitude. A field whose top bit is clear is unchanged. On the unsigned kind, abs has no effect and raises no flag.
- R5: With negate on the signed kind, a value whose field top bit is set is sign-extended and then negated in 32 bits. A value whose field top bit is clear is left unchanged.
- R6: With sign-extend on the signed kind, the field's top bit is copied into every bit above the field.
- R7: The modifiers are applied abs first, negate second and sign-extend last. Each step tests the field top bit of the previous step's result.
- R8: For the float kind (2), abs clears the field's top bit and negate inverts it. All other bits, including the zero bits above the field, are kept.
- R9: Negate or sign-extend on the unsigned kind (0), sign-extend on the float kind, and kind code 3 each raise the illegal flag. In each case the output is the zero-extended field with no modifier applied.
- R10: Every other combination, with a select code of 6 or below, leaves the illegal flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lane_i | input | 32 | Source lane value |
| field_sel_i | input | 3 | Field select code (0-3 byte, 4-5 half, 6 word) |
| op_kind_i | input | 2 | Operand kind: 0 unsigned, 1 signed, 2 float, 3 reserved |
| mod_abs_i | input | 1 | Absolute-value modifier request |
| mod_neg_i | input | 1 | Negate modifier request |
| mod_sext_i | input | 1 | Sign-extend modifier request |
| result_o | output | 32 | Modified operand |
| illegal_o | output | 1 | Illegal select or modifier combination |

## Verification
The hardest case to reach is a chain where one step changes the sign bit that the next step tests. One example is a signed byte 0x80: its magnitude is still 0x80, so negate fires again and sign-extend then fills the upper bits. Another is a full-word 0x80000000, whose magnitude overflows back to itself. The stimulus table contains these cases on purpose, next to the plain single-modifier cases, so that a wrong step order or a test against the original field is seen. A sweep over all select codes checks where the flag turns on.

// File: rtl/opsel_pkg.sv
package opsel_pkg;

    localparam int LANE_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int HALF_W    = 16;
    localparam int SEL_W     = 3;
    localparam int KIND_W    = 2;
    localparam int NUM_BYTES = LANE_W / BYTE_W;
    localparam int NUM_HALVES = LANE_W / HALF_W;
    localparam int BYTE_IDX_W = $clog2(NUM_BYTES);
    localparam int HALF_IDX_W = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;
    localparam logic [SEL_W-1:0] SEL_HALF_BASE = SEL_W'(NUM_BYTES);
    localparam logic [SEL_W-1:0] SEL_WORD      = SEL_W'(NUM_BYTES + NUM_HALVES);

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [KIND_W-1:0] {
        KIND_UINT  = 2'd0,
        KIND_SINT  = 2'd1,
        KIND_FLOAT = 2'd2,
        KIND_RSVD  = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        FW_BYTE = 2'd0,
        FW_HALF = 2'd1,
        FW_WORD = 2'd2
    } fwidth_e;

    typedef struct packed {
        lane_t   value;
        fwidth_e width;
        logic    reserved;
    } field_t;

    typedef struct packed {
        logic do_abs;
        logic do_neg;
        logic do_sext;
    } mods_t;

    // Ones over the bits of the field, zeros above it.
    function automatic lane_t width_mask(input fwidth_e w);
        case (w)
            FW_BYTE: width_mask = {{(LANE_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            FW_HALF: width_mask = {{(LANE_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            default: width_mask = {LANE_W{1'b1}};
        endcase
    endfunction

    // A single one at the top bit of the field.
    function automatic lane_t top_bit_mask(input fwidth_e w);
        lane_t m;
        m = width_mask(w);
        top_bit_mask = m & ~(m >> 1);
    endfunction

    function automatic logic top_bit(input lane_t v, input fwidth_e w);
        top_bit = |(v & top_bit_mask(w));
    endfunction

    // Copy the field's top bit over all bits above the field.
    function automatic lane_t fill_upper(input lane_t v, input fwidth_e w);
        lane_t m;
        m = width_mask(w);
        fill_upper = top_bit(v, w) ? (v | ~m) : (v & m);
    endfunction

endpackage

// File: rtl/opsel_field_extract.sv
module opsel_field_extract
    import opsel_pkg::*;
(
    input  lane_t               lane_i,
    input  logic [SEL_W-1:0]    sel_i,
    output field_t              field_o
);

    logic [BYTE_W-1:0] byte_arr [NUM_BYTES];
    logic [HALF_W-1:0] half_arr [NUM_HALVES];

    for (genvar gb = 0; gb < NUM_BYTES; gb++) begin : g_bytes
        assign byte_arr[gb] = lane_i[gb*BYTE_W +: BYTE_W];
    end

    for (genvar gh = 0; gh < NUM_HALVES; gh++) begin : g_halves
        assign half_arr[gh] = lane_i[gh*HALF_W +: HALF_W];
    end

    logic [BYTE_IDX_W-1:0] byte_idx;
    logic [HALF_IDX_W-1:0] half_idx;
    assign byte_idx = sel_i[BYTE_IDX_W-1:0];
    assign half_idx = HALF_IDX_W'(sel_i - SEL_HALF_BASE);

    always_comb begin
        field_o.reserved = 1'b0;
        if (sel_i < SEL_HALF_BASE) begin
            field_o.value = lane_t'(byte_arr[byte_idx]);
            field_o.width = FW_BYTE;
        end else if (sel_i < SEL_WORD) begin
            field_o.value = lane_t'(half_arr[half_idx]);
            field_o.width = FW_HALF;
        end else if (sel_i == SEL_WORD) begin
            field_o.value = lane_i;
            field_o.width = FW_WORD;
        end else begin
            field_o.value    = lane_i;
            field_o.width    = FW_WORD;
            field_o.reserved = 1'b1;
        end
    end

endmodule

// File: rtl/opsel_int_chain.sv
module opsel_int_chain
    import opsel_pkg::*;
(
    input  field_t   field_i,
    input  logic     is_signed_i,
    input  mods_t    mods_i,
    output lane_t    value_o
);

    lane_t after_abs;
    lane_t after_neg;
    lane_t after_ext;

    // Step 1: magnitude, signed kind only, and only when the top bit is set.
    always_comb begin
        after_abs = field_i.value;
        if (mods_i.do_abs && is_signed_i && top_bit(field_i.value, field_i.width))
            after_abs = -fill_upper(field_i.value, field_i.width);
    end

    // Step 2: negation, tested against the step-1 result.
    always_comb begin
        after_neg = after_abs;
        if (mods_i.do_neg && top_bit(after_abs, field_i.width))
            after_neg = -fill_upper(after_abs, field_i.width);
    end

    // Step 3: sign extension, tested against the step-2 result.
    always_comb begin
        after_ext = after_neg;
        if (mods_i.do_sext && top_bit(after_neg, field_i.width))
            after_ext = fill_upper(after_neg, field_i.width);
    end

    assign value_o = after_ext;

endmodule

// File: rtl/opsel_fp_chain.sv
module opsel_fp_chain
    import opsel_pkg::*;
(
    input  field_t   field_i,
    input  mods_t    mods_i,
    output lane_t    value_o
);

    lane_t sign_m;
    lane_t after_abs;

    assign sign_m = top_bit_mask(field_i.width);

    always_comb begin
        after_abs = field_i.value;
        if (mods_i.do_abs)
            after_abs = field_i.value & ~sign_m;
    end

    always_comb begin
        value_o = after_abs;
        if (mods_i.do_neg)
            value_o = after_abs ^ sign_m;
    end

endmodule

// File: rtl/opsel_modify_unit.sv
module opsel_modify_unit
    import opsel_pkg::*;
(
    input  logic [LANE_W-1:0]  lane_i,
    input  logic [SEL_W-1:0]   field_sel_i,
    input  logic [KIND_W-1:0]  op_kind_i,
    input  logic               mod_abs_i,
    input  logic               mod_neg_i,
    input  logic               mod_sext_i,
    output logic [LANE_W-1:0]  result_o,
    output logic               illegal_o
);

    field_t   field;
    mods_t    mods;
    op_kind_e kind;
    lane_t    int_val;
    lane_t    fp_val;
    logic     combo_bad;

    assign kind = op_kind_e'(op_kind_i);
    assign mods = '{do_abs: mod_abs_i, do_neg: mod_neg_i, do_sext: mod_sext_i};

    opsel_field_extract u_extract (
        .lane_i  (lane_i),
        .sel_i   (field_sel_i),
        .field_o (field)
    );

    opsel_int_chain u_int (
        .field_i     (field),
        .is_signed_i (kind == KIND_SINT),
        .mods_i      (mods),
        .value_o     (int_val)
    );

    opsel_fp_chain u_fp (
        .field_i (field),
        .mods_i  (mods),
        .value_o (fp_val)
    );

    always_comb begin
        case (kind)
            KIND_UINT:  combo_bad = mods.do_neg | mods.do_sext;
            KIND_SINT:  combo_bad = 1'b0;
            KIND_FLOAT: combo_bad = mods.do_sext;
            default:    combo_bad = 1'b1;
        endcase
    end

    always_comb begin
        illegal_o = field.reserved | combo_bad;
        if (illegal_o)
            result_o = field.value;
        else if (kind == KIND_FLOAT)
            result_o = fp_val;
        else
            result_o = int_val;
    end

endmodule

// File: rtl/opsel_modify_checker.sv
module opsel_modify_checker
    import opsel_pkg::*;
(
    input  logic [LANE_W-1:0]  lane_i,
    input  logic [SEL_W-1:0]   field_sel_i,
    input  logic [KIND_W-1:0]  op_kind_i,
    input  logic               mod_abs_i,
    input  logic               mod_neg_i,
    input  logic               mod_sext_i,
    input  logic [LANE_W-1:0]  result_o,
    input  logic               illegal_o
);

    logic known;
    logic no_mods;
    assign known = !$isunknown({lane_i, field_sel_i, op_kind_i, mod_abs_i,
                                mod_neg_i, mod_sext_i, result_o, illegal_o});
    assign no_mods = !mod_abs_i && !mod_neg_i && !mod_sext_i;

    always_comb begin
        if (known) begin
            // R3: reserved select passes the lane through and flags it
            if (field_sel_i > SEL_WORD)
                assert_rsvd_sel_R3: assert (illegal_o && result_o == lane_i)
                    else $error("reserved select not trapped");
            // R9: unsigned kind with negate or extend is flagged
            if (op_kind_i == KIND_UINT && (mod_neg_i || mod_sext_i))
                assert_uint_bad_R9: assert (illegal_o)
                    else $error("unsigned modifier not flagged");
            // R9: float kind with extend is flagged
            if (op_kind_i == KIND_FLOAT && mod_sext_i)
                assert_fp_sext_R9: assert (illegal_o)
                    else $error("float extend not flagged");
            // R1: plain byte select has no bits above the byte
            if (field_sel_i < SEL_HALF_BASE && no_mods && op_kind_i != KIND_RSVD)
                assert_byte_zext_R1: assert (result_o[LANE_W-1:BYTE_W] == '0 && !illegal_o)
                    else $error("byte select not zero-extended");
            // R6: signed byte extend alone yields a uniform upper part
            if (field_sel_i < SEL_HALF_BASE && op_kind_i == KIND_SINT &&
                mod_sext_i && !mod_abs_i && !mod_neg_i)
                assert_byte_sext_R6: assert (result_o[LANE_W-1:BYTE_W] ==
                                             {(LANE_W-BYTE_W){result_o[BYTE_W-1]}})
                    else $error("sign extend not uniform");
            // R8: float abs alone on a byte leaves the top bit clear
            if (field_sel_i < SEL_HALF_BASE && op_kind_i == KIND_FLOAT &&
                mod_abs_i && !mod_neg_i && !mod_sext_i)
                assert_fp_abs_R8: assert (result_o[LANE_W-1:BYTE_W-1] == '0)
                    else $error("float abs left sign set");
        end
    end

endmodule

bind opsel_modify_unit opsel_modify_checker u_chk (
    .lane_i      (lane_i),
    .field_sel_i (field_sel_i),
    .op_kind_i   (op_kind_i),
    .mod_abs_i   (mod_abs_i),
    .mod_neg_i   (mod_neg_i),
    .mod_sext_i  (mod_sext_i),
    .result_o    (result_o),
    .illegal_o   (illegal_o)
);

// File: tb/sim_opsel_modify_unit.sv
module sim_opsel_modify_unit;

    logic        clk = 1'b0;
    logic [31:0] lane;
    logic [2:0]  sel;
    logic [1:0]  kind;
    logic        m_abs, m_neg, m_sext;
    logic [31:0] result;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    opsel_modify_unit u0 (
        .lane_i      (lane),
        .field_sel_i (sel),
        .op_kind_i   (kind),
        .mod_abs_i   (m_abs),
        .mod_neg_i   (m_neg),
        .mod_sext_i  (m_sext),
        .result_o    (result),
        .illegal_o   (illegal)
    );

    // Vector: lane, sel, kind, abs, neg, sext, expected result, expected flag, req
    localparam int NV = 28;
    localparam logic [80:0] VECS [NV] = '{
        {32'hA1B2C3D4, 3'd0, 2'd0, 3'b000, 32'h000000D4, 1'b0, 8'd1},  // R1
        {32'hA1B2C3D4, 3'd3, 2'd0, 3'b000, 32'h000000A1, 1'b0, 8'd1},  // R1
        {32'hA1B2C3D4, 3'd1, 2'd1, 3'b000, 32'h000000C3, 1'b0, 8'd1},  // R1
        {32'hA1B2C3D4, 3'd4, 2'd0, 3'b000, 32'h0000C3D4, 1'b0, 8'd2},  // R2
        {32'hA1B2C3D4, 3'd5, 2'd0, 3'b000, 32'h0000A1B2, 1'b0, 8'd2},  // R2
        {32'hA1B2C3D4, 3'd6, 2'd0, 3'b000, 32'hA1B2C3D4, 1'b0, 8'd2},  // R2
        {32'hA1B2C3D4, 3'd7, 2'd1, 3'b001, 32'hA1B2C3D4, 1'b1, 8'd3},  // R3
        {32'h000000F0, 3'd0, 2'd1, 3'b100, 32'h00000010, 1'b0, 8'd4},  // R4
        {32'h00000070, 3'd0, 2'd1, 3'b100, 32'h00000070, 1'b0, 8'd4},  // R4
        {32'h000000F0, 3'd0, 2'd0, 3'b100, 32'h000000F0, 1'b0, 8'd4},  // R4
        {32'h0000F000, 3'd1, 2'd1, 3'b010, 32'h00000010, 1'b0, 8'd5},  // R5
        {32'h00000005, 3'd0, 2'd1, 3'b010, 32'h00000005, 1'b0, 8'd5},  // R5
        {32'h80010000, 3'd5, 2'd1, 3'b010, 32'h00007FFF, 1'b0, 8'd5},  // R5
        {32'h00000080, 3'd0, 2'd1, 3'b001, 32'hFFFFFF80, 1'b0, 8'd6},  // R6
        {32'h80010000, 3'd5, 2'd1, 3'b001, 32'hFFFF8001, 1'b0, 8'd6},  // R6
        {32'h0000007F, 3'd0, 2'd1, 3'b001, 32'h0000007F, 1'b0, 8'd6},  // R6
        {32'h000000F0, 3'd0, 2'd1, 3'b110, 32'h00000010, 1'b0, 8'd7},  // R7
        {32'h00000080, 3'd0, 2'd1, 3'b111, 32'hFFFFFF80, 1'b0, 8'd7},  // R7
        {32'h000000F0, 3'd0, 2'd1, 3'b011, 32'h00000010, 1'b0, 8'd7},  // R7
        {32'h80000000, 3'd6, 2'd1, 3'b110, 32'h80000000, 1'b0, 8'd7},  // R7
        {32'h0000C000, 3'd4, 2'd2, 3'b100, 32'h00004000, 1'b0, 8'd8},  // R8
        {32'h00004000, 3'd4, 2'd2, 3'b010, 32'h0000C000, 1'b0, 8'd8},  // R8
        {32'hC0000000, 3'd6, 2'd2, 3'b110, 32'hC0000000, 1'b0, 8'd8},  // R8
        {32'h000000AB, 3'd0, 2'd0, 3'b010, 32'h000000AB, 1'b1, 8'd9},  // R9
        {32'h000000AB, 3'd0, 2'd0, 3'b001, 32'h000000AB, 1'b1, 8'd9},  // R9
        {32'h00001234, 3'd4, 2'd2, 3'b001, 32'h00001234, 1'b1, 8'd9},  // R9
        {32'h12345678, 3'd2, 2'd3, 3'b000, 32'h00000034, 1'b1, 8'd9},  // R9
        {32'h00000012, 3'd0, 2'd2, 3'b110, 32'h00000092, 1'b0, 8'd10}  // R10
    };

    task automatic apply(input logic [31:0] l, input logic [2:0] s,
                         input logic [1:0] k, input logic [2:0] m);
        @(negedge clk);
        lane = l; sel = s; kind = k;
        {m_abs, m_neg, m_sext} = m;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input int req, input logic [31:0] exp_r, input logic exp_f);
        n_checks++;
        if (result !== exp_r || illegal !== exp_f) begin
            n_fail++;
            $display("FAIL R%0d: result=%h flag=%b expected result=%h flag=%b",
                     req, result, illegal, exp_r, exp_f);
        end
    endtask

    initial begin
        lane = '0; sel = '0; kind = '0;
        m_abs = 1'b0; m_neg = 1'b0; m_sext = 1'b0;

        // Idle inputs: zero lane, byte 0, unsigned, no modifiers (R1, R10)
        apply(32'h0, 3'd0, 2'd0, 3'b000);
        check(1, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][80:49], VECS[i][48:46], VECS[i][45:44], VECS[i][43:41]);
            check(int'(VECS[i][7:0]), VECS[i][40:9], VECS[i][8]);
        end

        // R3 / R10: flag only for select codes above 6, signed, no modifiers
        for (int s = 0; s < 8; s++) begin
            logic [31:0] e;
            case (s)
                0: e = 32'h00000088;
                1: e = 32'h00000077;
                2: e = 32'h00000066;
                3: e = 32'h00000055;
                4: e = 32'h00007788;
                5: e = 32'h00005566;
                default: e = 32'h55667788;
            endcase
            apply(32'h55667788, 3'(s), 2'd1, 3'b000);
            check((s == 7) ? 3 : 10, e, s == 7);
        end

        // R3: reserved select with float and every modifier still passes through
        apply(32'hDEADBEEF, 3'd7, 2'd2, 3'b111);
        check(3, 32'hDEADBEEF, 1'b1);

        // R9: reserved kind with modifiers leaves the half unmodified
        apply(32'hFFFF8000, 3'd4, 2'd3, 3'b110);
        check(9, 32'h00008000, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule